// File: doc/BRIEF.md
# Audio DMA Request Router

This block sits between the sample engines of an audio codec and the host bus. It decides how each direction of sample traffic is serviced: by raising a DMA request line, or by setting a programmed-I/O ready flag that the host polls. A "sample needed" strobe drives playback and a "sample available" strobe drives capture. Each direction has an enable bit and a PIO-select bit. A single-channel mode bit folds all DMA traffic onto the playback request pin. When both directions are enabled in that mode, playback takes the channel outright and capture is shut off.

Each direction has a small request state machine with three states. In RQ_IDLE it waits for a strobe. In RQ_WAIT it drives the request until the matching acknowledge arrives. RQ_GAP holds the line low for a guaranteed number of clocks. The transitions are as follows:
- RQ_IDLE goes to RQ_WAIT when the direction is in DMA mode and a strobe arrives.
- RQ_WAIT goes to RQ_GAP when the acknowledge arrives.
- RQ_WAIT and RQ_GAP go back to RQ_IDLE when the direction stops being in DMA mode.
- RQ_GAP goes to RQ_WAIT at the end of the gap if a strobe arrived during the gap or on its last cycle. Otherwise it goes to RQ_IDLE.

Each direction also has a PIO flag machine with two states. FL_EMPTY goes to FL_READY on a strobe in PIO mode. FL_READY goes back to FL_EMPTY on a host access strobe, or when the direction leaves PIO mode.

Top module: `adr_router`

## Requirements
- R1: `play_drq` comes from the playback machine only while `play_en`=1 and `play_pio`=0. With that configuration, a `play_need` strobe raises `play_drq` on the following clock.
- R2: With `play_en`=1 and `play_pio`=1, a `play_need` strobe leaves `play_drq` low and sets `play_pio_rdy` on the following clock.
- R3: With `play_en`=0, `play_pio_rdy` stays low and playback raises no request, whatever `play_need` does.
- R4: `cap_drq` rises on the clock after a `cap_avail` strobe only when `cap_en`=1, `cap_pio`=0 and `single_chan`=0. With `cap_en`=1 and `cap_pio`=1, the strobe sets `cap_pio_rdy` instead.
- R5: With `single_chan`=1, `cap_drq` is always 0. A capture request comes out on `play_drq` and is answered by `play_ack`; `cap_ack` is ignored.
- R6: With `single_chan`=1 and both `play_en` and `cap_en` set, capture is suppressed. It raises no request and `cap_pio_rdy` stays 0, whether capture is set to DMA or PIO.
- R7: A request stays high from the clock after its strobe until an acknowledge is sampled; strobes seen while it is high add no further request. On the clock after the acknowledge the request goes low and stays low for GAP_CYCLES clocks (default 1).
- R8: A strobe that arrives during the gap is held. The request rises again on the clock after the gap ends, without another strobe.
- R9: A PIO ready flag is cleared on the clock after its host strobe (`host_play_wr` or `host_cap_rd`). If a new sample strobe arrives in the same cycle as the host strobe, the flag stays set.
- R10: Enable bits take effect at any time. Clearing an enable drops that direction's request and ready flag at once, and returns its machines to idle. Setting the enable again raises nothing until a new strobe.
- R11: While `rst_n` is low, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| play_en | input | 1 | Playback enable |
| play_pio | input | 1 | Playback uses PIO (1) or DMA (0) |
| cap_en | input | 1 | Capture enable |
| cap_pio | input | 1 | Capture uses PIO (1) or DMA (0) |
| single_chan | input | 1 | All DMA traffic on the playback channel |
| play_need | input | 1 | Playback sample-needed strobe |
| cap_avail | input | 1 | Capture sample-available strobe |
| play_ack | input | 1 | Acknowledge on the playback DMA channel |
| cap_ack | input | 1 | Acknowledge on the capture DMA channel |
| host_play_wr | input | 1 | Host PIO write of a playback sample |
| host_cap_rd | input | 1 | Host PIO read of a capture sample |
| play_drq | output | 1 | Playback-channel DMA request |
| cap_drq | output | 1 | Capture-channel DMA request |
| play_pio_rdy | output | 1 | Playback PIO ready flag |
| cap_pio_rdy | output | 1 | Capture PIO ready flag |

## Verification
The routing function is driven with every meaningful mix of the enable, PIO-select and single-channel bits, with and without strobes. This separates DMA gating from PIO gating, dual-channel from single-channel routing, and the single-channel capture suppression from plain capture service.

Directed sequences then cover the request lifecycle: holding the request without an acknowledge, the gap after the acknowledge, and a strobe landing inside the gap. They also cover which acknowledge answers a folded capture request, a set and clear of a ready flag in the same cycle, and dropping an enable in mid-request.

// File: rtl/adr_pkg.sv
package adr_pkg;

    typedef enum logic [1:0] {
        RQ_IDLE = 2'd0,
        RQ_WAIT = 2'd1,
        RQ_GAP  = 2'd2
    } req_state_t;

    typedef enum logic {
        FL_EMPTY = 1'b0,
        FL_READY = 1'b1
    } flag_state_t;

    localparam int N_DIR   = 2;
    localparam int DIR_PLY = 0;
    localparam int DIR_CAP = 1;

endpackage

// File: rtl/adr_req_fsm.sv
module adr_req_fsm
    import adr_pkg::*;
#(
    parameter int GAP_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic strobe,
    input  logic ack,
    output logic req
);
    localparam int CW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [CW-1:0] GAP_LOAD = CW'(GAP_CYCLES - 1);

    req_state_t    state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          pend, pend_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RQ_IDLE;
            cnt   <= '0;
            pend  <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            pend  <= pend_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            RQ_IDLE: begin
                if (go && strobe) state_n = RQ_WAIT;
            end
            RQ_WAIT: begin
                if (!go)      state_n = RQ_IDLE;
                else if (ack) state_n = RQ_GAP;
            end
            RQ_GAP: begin
                if (!go)
                    state_n = RQ_IDLE;
                else if (cnt == '0)
                    state_n = (pend || strobe) ? RQ_WAIT : RQ_IDLE;
            end
            default: state_n = RQ_IDLE;
        endcase
    end

    always_comb begin
        cnt_n = cnt;
        if (state == RQ_WAIT && state_n == RQ_GAP)
            cnt_n = GAP_LOAD;
        else if (state == RQ_GAP && cnt != '0)
            cnt_n = cnt - 1'b1;
        pend_n = (state == RQ_GAP && state_n == RQ_GAP) ? (pend || (go && strobe)) : 1'b0;
    end

    always_comb begin
        req = (state == RQ_WAIT) && go;
    end

endmodule

// File: rtl/adr_pio_flag.sv
module adr_pio_flag
    import adr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic set,
    input  logic clr,
    output logic rdy
);
    flag_state_t state, state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FL_EMPTY;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            FL_EMPTY: begin
                if (go && set) state_n = FL_READY;
            end
            FL_READY: begin
                if (!go)              state_n = FL_EMPTY;
                else if (clr && !set) state_n = FL_EMPTY;
            end
            default: state_n = FL_EMPTY;
        endcase
    end

    always_comb begin
        rdy = (state == FL_READY) && go;
    end

endmodule

// File: rtl/adr_route.sv
module adr_route (
    input  logic       play_en,
    input  logic       play_pio,
    input  logic       cap_en,
    input  logic       cap_pio,
    input  logic       single_chan,
    input  logic       play_ack,
    input  logic       cap_ack,
    input  logic [1:0] req,
    output logic [1:0] dma_go,
    output logic [1:0] pio_go,
    output logic [1:0] fsm_ack,
    output logic       play_drq,
    output logic       cap_drq
);
    logic cap_blocked;

    always_comb begin
        cap_blocked = single_chan && play_en;
        dma_go[0]   = play_en && !play_pio;
        pio_go[0]   = play_en && play_pio;
        dma_go[1]   = cap_en && !cap_pio && !cap_blocked;
        pio_go[1]   = cap_en && cap_pio && !cap_blocked;
        fsm_ack[0]  = play_ack;
        fsm_ack[1]  = single_chan ? play_ack : cap_ack;
        play_drq    = req[0] || (single_chan && req[1]);
        cap_drq     = !single_chan && req[1];
    end

endmodule

// File: rtl/adr_router.sv
module adr_router
    import adr_pkg::*;
#(
    parameter int GAP_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic play_en,
    input  logic play_pio,
    input  logic cap_en,
    input  logic cap_pio,
    input  logic single_chan,
    input  logic play_need,
    input  logic cap_avail,
    input  logic play_ack,
    input  logic cap_ack,
    input  logic host_play_wr,
    input  logic host_cap_rd,
    output logic play_drq,
    output logic cap_drq,
    output logic play_pio_rdy,
    output logic cap_pio_rdy
);
    logic [N_DIR-1:0] dma_go, pio_go, fsm_ack, req, strobe, host_clr, rdy;

    assign strobe   = {cap_avail, play_need};
    assign host_clr = {host_cap_rd, host_play_wr};

    adr_route u_route (
        .play_en     (play_en),
        .play_pio    (play_pio),
        .cap_en      (cap_en),
        .cap_pio     (cap_pio),
        .single_chan (single_chan),
        .play_ack    (play_ack),
        .cap_ack     (cap_ack),
        .req         (req),
        .dma_go      (dma_go),
        .pio_go      (pio_go),
        .fsm_ack     (fsm_ack),
        .play_drq    (play_drq),
        .cap_drq     (cap_drq)
    );

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        adr_req_fsm #(.GAP_CYCLES(GAP_CYCLES)) u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .go     (dma_go[d]),
            .strobe (strobe[d]),
            .ack    (fsm_ack[d]),
            .req    (req[d])
        );
        adr_pio_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .go    (pio_go[d]),
            .set   (strobe[d]),
            .clr   (host_clr[d]),
            .rdy   (rdy[d])
        );
    end

    assign play_pio_rdy = rdy[DIR_PLY];
    assign cap_pio_rdy  = rdy[DIR_CAP];

endmodule

// File: rtl/adr_router_checker.sv
module adr_router_checker (
    input logic clk,
    input logic rst_n,
    input logic play_en,
    input logic play_pio,
    input logic cap_en,
    input logic cap_pio,
    input logic single_chan,
    input logic play_need,
    input logic cap_avail,
    input logic play_ack,
    input logic cap_ack,
    input logic host_play_wr,
    input logic host_cap_rd,
    input logic play_drq,
    input logic cap_drq,
    input logic play_pio_rdy,
    input logic cap_pio_rdy
);
    a_r1_play_drq_source: assert property (@(posedge clk) disable iff (!rst_n)
        play_drq |-> ((play_en && !play_pio) || (single_chan && !play_en && cap_en && !cap_pio)));

    a_r2_pio_no_drq: assert property (@(posedge clk) disable iff (!rst_n)
        (play_en && play_pio) |-> !play_drq);

    a_r3_disabled_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !play_en |-> !play_pio_rdy);

    a_r4_cap_drq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        cap_drq |-> (cap_en && !cap_pio && !single_chan));

    a_r5_single_cap_low: assert property (@(posedge clk) disable iff (!rst_n)
        single_chan |-> !cap_drq);

    a_r6_single_both_no_cap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (single_chan && play_en && cap_en) |-> !cap_pio_rdy);

    a_r7_play_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (play_drq && play_ack) |=> !play_drq);

    a_r7_cap_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_drq && cap_ack) |=> !cap_drq);

    a_r9_flag_mode: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pio_rdy |-> (cap_en && cap_pio));

endmodule

bind adr_router adr_router_checker chk (.*);

// File: tb/adr_router_test.sv
module adr_router_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic play_en = 0, play_pio = 0, cap_en = 0, cap_pio = 0, single_chan = 0;
    logic play_need = 0, cap_avail = 0, play_ack = 0, cap_ack = 0;
    logic host_play_wr = 0, host_cap_rd = 0;
    logic play_drq, cap_drq, play_pio_rdy, cap_pio_rdy;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    adr_router uut (.*);

    // {tag[3:0], pe,pp,ce,cp,sc,pn,ca, exp pd,cd,prdy,crdy}
    localparam int NV = 12;
    localparam logic [14:0] VEC [NV] = '{
        {4'd1,  7'b1000010, 4'b1000},
        {4'd2,  7'b1100010, 4'b0010},
        {4'd3,  7'b0000011, 4'b0000},
        {4'd4,  7'b0010001, 4'b0100},
        {4'd4,  7'b0011001, 4'b0001},
        {4'd5,  7'b0010101, 4'b1000},
        {4'd6,  7'b1010111, 4'b1000},
        {4'd6,  7'b1011111, 4'b1000},
        {4'd1,  7'b1010011, 4'b1100},
        {4'd2,  7'b1111011, 4'b0011},
        {4'd3,  7'b0101011, 4'b0000},
        {4'd1,  7'b1000000, 4'b0000}
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [3:0] exp);
        check(req, "play_drq", play_drq, exp[3]);
        check(req, "cap_drq", cap_drq, exp[2]);
        check(req, "play_pio_rdy", play_pio_rdy, exp[1]);
        check(req, "cap_pio_rdy", cap_pio_rdy, exp[0]);
    endtask

    task automatic idle_all();
        play_en = 0; play_pio = 0; cap_en = 0; cap_pio = 0; single_chan = 0;
        play_need = 0; cap_avail = 0; play_ack = 0; cap_ack = 0;
        host_play_wr = 0; host_cap_rd = 0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        play_en = 1; play_need = 1; cap_en = 1; cap_avail = 1;
        repeat (3) @(negedge clk);
        check_all("R11", 4'b0000);
        idle_all();
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i][14:11]);
            {play_en, play_pio, cap_en, cap_pio, single_chan, play_need, cap_avail} = VEC[i][10:4];
            @(negedge clk);
            play_need = 0; cap_avail = 0;
            check_all(tag, VEC[i][3:0]);
            idle_all();
        end

        // R7: hold until ack, then gap
        play_en = 1; play_need = 1;
        @(negedge clk); play_need = 0;
        @(negedge clk); play_need = 1;
        @(negedge clk); play_need = 0;
        check("R7", "drq held without ack", play_drq, 1'b1);
        play_ack = 1;
        @(negedge clk); play_ack = 0;
        check("R7", "drq low after ack", play_drq, 1'b0);
        @(negedge clk);
        check("R7", "no extra request", play_drq, 1'b0);

        // R8: strobe during gap re-raises request
        play_need = 1;
        @(negedge clk); play_need = 0;
        check("R8", "request up", play_drq, 1'b1);
        play_ack = 1;
        @(negedge clk); play_ack = 0;
        check("R8", "gap low", play_drq, 1'b0);
        play_need = 1;
        @(negedge clk); play_need = 0;
        check("R8", "re-raised after gap", play_drq, 1'b1);

        // R10: drop enable mid-request, re-enable without strobe
        play_en = 0;
        #1 check("R10", "drq drops on disable", play_drq, 1'b0);
        @(negedge clk); play_en = 1;
        @(negedge clk);
        check("R10", "no request after re-enable", play_drq, 1'b0);
        idle_all();

        // R9: flag clear and set-wins
        play_en = 1; play_pio = 1; play_need = 1;
        @(negedge clk); play_need = 0;
        check("R9", "flag set", play_pio_rdy, 1'b1);
        host_play_wr = 1;
        @(negedge clk); host_play_wr = 0;
        check("R9", "flag cleared by host", play_pio_rdy, 1'b0);
        play_need = 1;
        @(negedge clk); play_need = 0;
        host_play_wr = 1; play_need = 1;
        @(negedge clk); host_play_wr = 0; play_need = 0;
        check("R9", "set wins over clear", play_pio_rdy, 1'b1);
        idle_all();

        // R5: folded capture answered by play_ack only
        single_chan = 1; cap_en = 1; cap_avail = 1;
        @(negedge clk); cap_avail = 0;
        check("R5", "capture on play_drq", play_drq, 1'b1);
        cap_ack = 1;
        @(negedge clk); cap_ack = 0;
        check("R5", "cap_ack ignored", play_drq, 1'b1);
        check("R5", "cap_drq low", cap_drq, 1'b0);
        play_ack = 1;
        @(negedge clk); play_ack = 0;
        check("R5", "play_ack answers capture", play_drq, 1'b0);
        idle_all();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule